// File: doc/BRIEF.md
# Card Clock Generator with Power-Save Gating

This block derives the clock for an SD/MMC card from the master clock. A 12-bit control word sets it up. The low byte is a divider, and four flags sit above it: enable, power-save, bypass and wide-bus. In divided mode the card clock runs at master/(2*(div+1)). This gives 400 kHz for divider 0x1D and 4 MHz for divider 0x02 when the master clock is 24 MHz. In bypass mode the master clock is passed straight through, and the divider value plays no part.

The command and data paths use two single-cycle strobes in the master domain, one for each rising and one for each falling card clock edge. These strobes let them shift bits without crossing into the card clock domain. The clock stops low when enable is clear. With power-save set, it also stops low whenever the bus-active input is low. A high phase that has already started always completes. Divider changes apply only from the start of the next low phase. A change between divided and bypass source happens only while both sources are low. The wide-bus flag is registered and passed on to the data path.

Top module: `cardclk_gen`

## Requirements
- R1: With enable (bit 8) set and bypass (bit 9+1 = bit 10) clear, the card clock has a period of 2*(div+1) master cycles and is high for div+1 of them, where div is bits 7:0.
- R2: While reset is asserted, the card clock, both strobes and the wide-bus output are low, whatever the control word holds.
- R3: With enable (bit 8) clear, the card clock stays low and neither strobe fires. An all-zero control word therefore stops the clock.
- R4: With power-save (bit 9) set, the card clock runs only while bus_active_i is high. When bus_active_i drops during a high phase, that high phase completes at its normal length and the clock then stays low.
- R5: With bypass (bit 10) and enable set, the card clock pulses once every master cycle whatever the divider holds, and both strobes stay high in every such cycle.
- R6: A new divider value written during a high phase does not change that high phase. It takes effect from the low phase that follows.
- R7: The rise strobe is high for exactly those master cycles that begin with a rising card clock edge, and the fall strobe for those that begin with a falling edge. In divided mode the two are never high together.
- R8: A change of source between divided and bypass stops the clock low first, so no card clock high or low pulse is shorter than half a master period.
- R9: The wide-bus flag (bit 11) appears on wide_bus_o one master cycle after it is written.
- R10: Divider 0x1D gives a period of 60 master cycles (at most 400 kHz from 24 MHz), and divider 0x02 gives a period of 6 (4 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_i | input | 12 | Control word: divider 7:0, enable 8, power-save 9, bypass 10, wide-bus 11 |
| bus_active_i | input | 1 | High while the command or data path needs the clock |
| card_clk_o | output | 1 | Card clock |
| rise_stb_o | output | 1 | One master cycle per rising card clock edge |
| fall_stb_o | output | 1 | One master cycle per falling card clock edge |
| wide_bus_o | output | 1 | Registered wide-bus flag for the data path |

## Verification
The properties assume that ctrl_i and bus_active_i change only at master-clock rising edges, as a register in the same domain would drive them. They also assume that the master clock is free-running, so that the bypass gate, which updates on the falling edge, sees settled inputs. The bench drives every input one time unit after a rising edge and samples there as well, so it stays within these assumptions. The source-switch and power-save properties rely on the divided clock being held in reset until the synchronized reset releases. The bench therefore begins its checks only after that release.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;
  localparam int CC_DIV_W = 8;

  typedef enum logic {
    SRC_DIV    = 1'b0,
    SRC_MASTER = 1'b1
  } cc_src_e;
endpackage

// File: rtl/cardclk_rst_sync.sv
module cardclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/cardclk_div.sv
module cardclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             clk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] lim_q, lim_d;
  logic             ph_q, ph_d;
  logic             rise_d, fall_d;
  logic             tick;

  always_comb begin
    tick   = (cnt_q == lim_q);
    cnt_d  = cnt_q + 1'b1;
    lim_d  = lim_q;
    ph_d   = ph_q;
    rise_d = 1'b0;
    fall_d = 1'b0;
    if (ph_q) begin
      // high phase always runs to its full length
      if (tick) begin
        ph_d   = 1'b0;
        cnt_d  = '0;
        fall_d = 1'b1;
        lim_d  = div_i;
      end
    end else if (!run_i) begin
      // parked low; keep tracking the divider
      cnt_d = '0;
      lim_d = div_i;
    end else if (tick) begin
      ph_d   = 1'b1;
      cnt_d  = '0;
      rise_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lim_q  <= '0;
      ph_q   <= 1'b0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lim_q  <= lim_d;
      ph_q   <= ph_d;
      rise_o <= rise_d;
      fall_o <= fall_d;
    end
  end

  assign clk_o = ph_q;
endmodule

// File: rtl/cardclk_bypass_gate.sv
module cardclk_bypass_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic gate_o
);
  // enable updated while the master clock is low, so the AND never glitches
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_o <= 1'b0;
    else         gate_o <= run_i;
  end
endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen
  import cardclk_pkg::*;
#(
  parameter int DIV_W = CC_DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W+3:0] ctrl_i,
  input  logic             bus_active_i,
  output logic             card_clk_o,
  output logic             rise_stb_o,
  output logic             fall_stb_o,
  output logic             wide_bus_o
);
  localparam int EN_BIT = DIV_W;
  localparam int PS_BIT = DIV_W + 1;
  localparam int BY_BIT = DIV_W + 2;
  localparam int WB_BIT = DIV_W + 3;

  logic    rst_n;
  cc_src_e src_q, src_d;
  logic    on_master, want_master, run_req;
  logic    div_clk, div_rise, div_fall, gate_q;
  logic    byp_stb_q, byp_stb_d;
  logic    wide_q, wide_d;

  cardclk_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  always_comb begin
    on_master   = (src_q == SRC_MASTER);
    want_master = ctrl_i[BY_BIT];
    run_req     = ctrl_i[EN_BIT] & (~ctrl_i[PS_BIT] | bus_active_i)
                  & (want_master == on_master);
    src_d       = src_q;
    if ((want_master != on_master) && !div_clk && !gate_q)
      src_d = want_master ? SRC_MASTER : SRC_DIV;
    byp_stb_d   = on_master & gate_q;
    wide_d      = ctrl_i[WB_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      src_q     <= SRC_DIV;
      byp_stb_q <= 1'b0;
      wide_q    <= 1'b0;
    end else begin
      src_q     <= src_d;
      byp_stb_q <= byp_stb_d;
      wide_q    <= wide_d;
    end
  end

  cardclk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .run_i  (run_req & ~on_master),
    .div_i  (ctrl_i[DIV_W-1:0]),
    .clk_o  (div_clk),
    .rise_o (div_rise),
    .fall_o (div_fall)
  );

  cardclk_bypass_gate u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .run_i  (run_req & on_master),
    .gate_o (gate_q)
  );

  assign card_clk_o = on_master ? (clk_i & gate_q) : div_clk;
  assign rise_stb_o = on_master ? byp_stb_q : div_rise;
  assign fall_stb_o = on_master ? byp_stb_q : div_fall;
  assign wide_bus_o = wide_q;
endmodule

// File: rtl/cardclk_gen_chk.sv
module cardclk_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic psave_i,
  input logic bus_active_i,
  input logic rise_stb_o,
  input logic fall_stb_o,
  input logic byp_q,
  input logic div_clk,
  input logic gate_q
);
  AST_STOP_HOLDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !div_clk && !byp_q) |=> !div_clk); // R3

  AST_PSAVE_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && psave_i && !bus_active_i && !div_clk && !byp_q) |=> !div_clk); // R4

  AST_GATE_ONLY_MASTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byp_q |-> !gate_q); // R5

  AST_RISE_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byp_q && $rose(div_clk)) |-> rise_stb_o); // R7

  AST_FALL_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byp_q && $fell(div_clk)) |-> fall_stb_o); // R7

  AST_STB_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byp_q |-> !(rise_stb_o && fall_stb_o)); // R7

  AST_SWITCH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byp_q != $past(byp_q)) |-> (!$past(div_clk) && !$past(gate_q))); // R8
endmodule

bind cardclk_gen cardclk_gen_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (ctrl_i[DIV_W]),
  .psave_i      (ctrl_i[DIV_W+1]),
  .bus_active_i (bus_active_i),
  .rise_stb_o   (rise_stb_o),
  .fall_stb_o   (fall_stb_o),
  .byp_q        (on_master),
  .div_clk      (div_clk),
  .gate_q       (gate_q)
);

// File: tb/cardclk_gen_tb.sv
module cardclk_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  localparam logic [7:0] VEC_DIV [NVEC] = '{8'd0, 8'd1, 8'd2, 8'd5, 8'h1D, 8'hFF};
  localparam int         VEC_PER [NVEC] = '{2, 4, 6, 12, 60, 512};

  logic        clk, rst_n, bus_active;
  logic [11:0] ctrl;
  logic        card_clk, rise_stb, fall_stb, wide_bus;
  int          checks, errors;
  int          card_edges;
  time         t_hi, t_lo, min_hi, min_lo;
  logic        seen_hi, seen_lo;

  cardclk_gen dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .ctrl_i       (ctrl),
    .bus_active_i (bus_active),
    .card_clk_o   (card_clk),
    .rise_stb_o   (rise_stb),
    .fall_stb_o   (fall_stb),
    .wide_bus_o   (wide_bus)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    card_edges = 0; seen_hi = 1'b0; seen_lo = 1'b0;
    min_hi = 1000000; min_lo = 1000000; t_hi = 0; t_lo = 0;
  end
  always @(posedge card_clk) begin
    card_edges = card_edges + 1;
    t_hi = $time;
    if (seen_lo && ($time - t_lo) < min_lo) min_lo = $time - t_lo;
    seen_hi = 1'b1;
  end
  always @(negedge card_clk) begin
    t_lo = $time;
    if (seen_hi && ($time - t_hi) < min_hi) min_hi = $time - t_hi;
    seen_lo = 1'b1;
  end

  function automatic logic [11:0] mk(bit wb, bit by, bit ps, bit en, logic [7:0] dv);
    return {wb, by, ps, en, dv};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  // period and high length between two rise strobes; counts strobe mismatches
  task automatic measure(output int per, output int hi, output int bad);
    int   guard;
    logic prev;
    guard = 0;
    while (!rise_stb && guard < 2000) begin step(1); guard++; end
    per = 0; hi = 0; bad = 0;
    do begin
      hi += int'(card_clk);
      per++;
      prev = card_clk;
      step(1);
      if (rise_stb != (card_clk && !prev)) bad++;
      if (fall_stb != (!card_clk && prev)) bad++;
    end while (!rise_stb && per < 2000);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int per, hi, bad, e0, cnt, cnt2;
    checks = 0; errors = 0;
    rst_n = 1'b0; bus_active = 1'b0;
    ctrl = mk(1, 0, 0, 1, 8'd0);
    step(5);
    // R2: outputs quiet in reset even with enable and wide set
    chk(!card_clk && !rise_stb && !fall_stb && !wide_bus, "R2",
        {card_clk, rise_stb, fall_stb, wide_bus}, 0);
    ctrl = mk(0, 0, 0, 1, 8'd0);
    rst_n = 1'b1;
    step(4);

    // R1 / R7 / R10 vector table
    for (int v = 0; v < NVEC; v++) begin
      ctrl = mk(0, 0, 0, 1, VEC_DIV[v]);
      measure(per, hi, bad);
      measure(per, hi, bad);
      measure(per, hi, bad);
      chk(per == VEC_PER[v], "R1 period", per, VEC_PER[v]);
      chk(hi == VEC_PER[v] / 2, "R1 high", hi, VEC_PER[v] / 2);
      chk(bad == 0, "R7 strobes", bad, 0);
      if (VEC_DIV[v] == 8'h1D || VEC_DIV[v] == 8'h02)
        chk(per == VEC_PER[v], "R10 speed", per, VEC_PER[v]);
    end

    // R6: divider change during a high phase
    ctrl = mk(0, 0, 0, 1, 8'd3);
    measure(per, hi, bad);
    measure(per, hi, bad);
    ctrl = mk(0, 0, 0, 1, 8'd1);
    cnt = 0;
    while (card_clk && cnt < 100) begin cnt++; step(1); end
    cnt2 = 0;
    while (!card_clk && cnt2 < 100) begin cnt2++; step(1); end
    chk(cnt == 4, "R6 old high", cnt, 4);
    chk(cnt2 == 2, "R6 new low", cnt2, 2);

    // R3: zero control word stops the clock low
    ctrl = '0;
    step(20);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      cnt += int'(card_clk) + int'(rise_stb) + int'(fall_stb);
      step(1);
    end
    chk(cnt == 0, "R3 stopped", cnt, 0);

    // R4: power-save idle, active, then idle mid high phase
    ctrl = mk(0, 0, 1, 1, 8'd2);
    bus_active = 1'b0;
    step(10);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin cnt += int'(card_clk) + int'(rise_stb); step(1); end
    chk(cnt == 0, "R4 idle low", cnt, 0);
    bus_active = 1'b1;
    cnt = 0;
    for (int i = 0; i < 30; i++) begin step(1); cnt += int'(rise_stb); end
    chk(cnt == 5, "R4 active rises", cnt, 5);
    while (!rise_stb) step(1);
    bus_active = 1'b0;
    cnt = 0; cnt2 = 0;
    for (int i = 0; i < 20; i++) begin
      cnt += int'(card_clk);
      if (i > 0) cnt2 += int'(rise_stb);
      step(1);
    end
    chk(cnt == 3, "R4 high completes", cnt, 3);
    chk(cnt2 == 0, "R4 stays low", cnt2, 0);

    // R5: bypass ignores the divider
    ctrl = mk(0, 1, 0, 1, 8'd7);
    step(40);
    e0 = card_edges;
    cnt = 0;
    for (int i = 0; i < 20; i++) begin step(1); cnt += int'(rise_stb && fall_stb); end
    chk(card_edges - e0 == 20, "R5 edges", card_edges - e0, 20);
    chk(cnt == 20, "R5 strobes", cnt, 20);

    // R5 with power-save idle: bypass clock gated
    ctrl = mk(0, 1, 1, 1, 8'd7);
    step(4);
    e0 = card_edges;
    step(10);
    chk(card_edges == e0, "R5 gated", card_edges - e0, 0);

    // R8: back to divided source
    ctrl = mk(0, 0, 0, 1, 8'd3);
    measure(per, hi, bad);
    measure(per, hi, bad);
    chk(per == 8 && hi == 4, "R8 divided again", per, 8);
    chk(min_hi >= CLK_PERIOD / 2 && min_lo >= CLK_PERIOD / 2, "R8 min pulse",
        int'(min_hi < min_lo ? min_hi : min_lo), CLK_PERIOD / 2);

    // R9: wide-bus flag
    ctrl = mk(1, 0, 0, 1, 8'd3);
    chk(wide_bus == 1'b0, "R9 before", wide_bus, 0);
    step(1);
    chk(wide_bus == 1'b1, "R9 after", wide_bus, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule